// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block turns 32-bit logical byte addresses into 24-bit physical addresses for 4 KB pages. It holds a small table of recent page-to-frame mappings and searches every entry in parallel. Each lookup carries a read/write flag. The answer arrives one clock later: either a hit with the physical address, or a miss. A miss raises a request to an external page-table walker, and the block then waits for the walker to install the mapping through the insert port.

Each entry holds a valid bit, a modified (dirty) bit, a 20-bit logical page number and a 12-bit frame tag. The page number is logical address bits 31..12. The physical address is the frame tag in bits 23..12 followed by the unchanged offset, which is logical address bits 11..0.

When an insert needs a slot, the victim is chosen in this order:
- the lowest-numbered empty entry;
- otherwise the lowest-numbered unmodified entry;
- otherwise the entry under a rotating pointer.

Any mapping that is displaced is reported on an eviction output, together with its modified bit.

A small controller has two states. In `S_IDLE` lookups are accepted. In `S_WAIT` a miss is outstanding. Its transitions are:
- *miss* (`S_IDLE`→`S_WAIT`), taken when an accepted lookup finds no match;
- *fill* (`S_WAIT`→`S_IDLE`), taken on an accepted insert;
- *abort* (`S_WAIT`→`S_IDLE`), taken on flush;
- *stay*, in every other case.

Top module: `addr_xlat_tlb`

## Requirements
- R1: After reset every entry is empty, `lk_ready` is 1, and `miss_req`, `resp_valid` and `evict_valid` are 0.
- R2: A lookup accepted while `lk_ready` is 1 gives `resp_valid`=1 in the next cycle. If its page matches a valid entry, that response has `resp_hit`=1 and `resp_paddr` = {frame tag, addr[11:0]}.
- R3: A lookup that matches nothing gives `resp_hit`=0 and enters `S_WAIT`. In `S_WAIT`, `miss_req` is 1, `miss_page` holds addr[31:12], and `lk_ready` is 0. Lookups offered in `S_WAIT` are ignored and produce no response.
- R4: A write lookup (`lk_write`=1) that hits sets that entry's modified bit. A read hit leaves the bit unchanged. A newly inserted entry starts unmodified.
- R5: An insert (`ins_valid`=1 without flush) installs the mapping. In `S_WAIT` it also returns the block to `S_IDLE`, which drops `miss_req` and raises `lk_ready`.
- R6: If any entry is empty, an insert of a new page uses the lowest-numbered empty entry.
- R7: If all entries are valid, an insert of a new page replaces the lowest-numbered unmodified entry.
- R8: If every entry is valid and modified, an insert replaces the entry under a rotating pointer. The pointer starts at 0 and advances by one, with wrap, each time it is used.
- R9: One cycle after an insert displaces a valid entry, `evict_valid`=1, with `evict_page` and `evict_dirty` taken from the displaced entry. An insert into an empty entry gives `evict_valid`=0.
- R10: An insert whose page is already present overwrites that entry's frame tag and keeps its modified bit. It allocates nothing and reports no eviction.
- R11: `flush` empties every entry in one cycle and returns the block to `S_IDLE`. A lookup offered in the same cycle is dropped.
- R12: An insert in the same cycle as `flush` is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a write access |
| lk_addr | input | 32 | Logical byte address |
| lk_ready | output | 1 | Lookups accepted (state `S_IDLE`) |
| resp_valid | output | 1 | Lookup response strobe |
| resp_hit | output | 1 | Response found a mapping |
| resp_paddr | output | 24 | Translated physical address |
| miss_req | output | 1 | Walk request outstanding |
| miss_page | output | 20 | Page number to walk |
| ins_valid | input | 1 | Install a mapping |
| ins_page | input | 20 | Logical page number to install |
| ins_frame | input | 12 | Frame tag to install |
| flush | input | 1 | Empty the whole table |
| evict_valid | output | 1 | A valid mapping was displaced |
| evict_page | output | 20 | Displaced page number |
| evict_dirty | output | 1 | Displaced entry was modified |

## Verification
The bench builds the block with `N_ENTRIES` set to 4 and the address widths at their defaults. With only four entries, a handful of inserts fills the table. That brings every victim rule within reach: empty slot, lowest unmodified entry, and two successive uses of the rotating pointer. It also makes each choice visible through the eviction port. The small table further reaches the flush cases: flush during an outstanding miss, and flush colliding with an insert.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Controller states
    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_WAIT = 1'b1
    } tlb_state_e;

    // Which victim rule picked the slot
    typedef enum logic [1:0] {
        VIC_FREE  = 2'd0,
        VIC_CLEAN = 2'd1,
        VIC_RR    = 2'd2
    } victim_kind_e;

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int N_ENTRIES = 16,
    parameter int PG_W      = 20,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic [N_ENTRIES-1:0]           valid,
    input  logic [N_ENTRIES-1:0][PG_W-1:0] pages,
    input  logic [PG_W-1:0]                key,
    output logic [N_ENTRIES-1:0]           match,
    output logic                           any,
    output logic [IDX_W-1:0]               idx
);

    // Broadcast the key to every entry at once
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
        assign match[g] = valid[g] && (pages[g] == key);
    end

    assign any = |match;

    // Duplicates cannot exist, so any matching index will do; lowest wins
    always_comb begin
        idx = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic [N_ENTRIES-1:0] valid,
    input  logic [N_ENTRIES-1:0] dirty,
    input  logic [IDX_W-1:0]     rr_ptr,
    output logic [IDX_W-1:0]     vic_idx,
    output victim_kind_e         vic_kind
);

    logic             have_free, have_clean;
    logic [IDX_W-1:0] free_idx, clean_idx;

    always_comb begin
        have_free  = 1'b0;
        have_clean = 1'b0;
        free_idx   = '0;
        clean_idx  = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
            if (valid[i] && !dirty[i]) begin
                have_clean = 1'b1;
                clean_idx  = IDX_W'(i);
            end
        end

        if (have_free) begin
            vic_idx  = free_idx;
            vic_kind = VIC_FREE;
        end else if (have_clean) begin
            vic_idx  = clean_idx;
            vic_kind = VIC_CLEAN;
        end else begin
            vic_idx  = rr_ptr;
            vic_kind = VIC_RR;
        end
    end

endmodule

// File: rtl/tlb_fsm.sv
module tlb_fsm
    import tlb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lk_fire,
    input  logic lk_hit,
    input  logic ins_fire,
    input  logic flush,
    output logic ready,
    output logic waiting
);

    tlb_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: miss, fill, abort, stay
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (lk_fire && !lk_hit)        state_d = S_WAIT;
            S_WAIT: if (flush || ins_fire)         state_d = S_IDLE;
            default:                               state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ready   = 1'b0;
        waiting = 1'b0;
        unique case (state_q)
            S_IDLE:  ready   = 1'b1;
            S_WAIT:  waiting = 1'b1;
            default: ready   = 1'b0;
        endcase
    end

endmodule

// File: rtl/addr_xlat_tlb.sv
module addr_xlat_tlb
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int VA_W      = 32,
    parameter int PA_W      = 24,
    parameter int OFF_W     = 12,
    localparam int PG_W     = VA_W - OFF_W,
    localparam int FR_W     = PA_W - OFF_W,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lk_valid,
    input  logic            lk_write,
    input  logic [VA_W-1:0] lk_addr,
    output logic            lk_ready,
    output logic            resp_valid,
    output logic            resp_hit,
    output logic [PA_W-1:0] resp_paddr,
    output logic            miss_req,
    output logic [PG_W-1:0] miss_page,
    input  logic            ins_valid,
    input  logic [PG_W-1:0] ins_page,
    input  logic [FR_W-1:0] ins_frame,
    input  logic            flush,
    output logic            evict_valid,
    output logic [PG_W-1:0] evict_page,
    output logic            evict_dirty
);

    // Entry storage
    logic [N_ENTRIES-1:0]           ent_v, ent_d;
    logic [N_ENTRIES-1:0][PG_W-1:0] ent_pg;
    logic [N_ENTRIES-1:0][FR_W-1:0] ent_fr;

    logic [PG_W-1:0] lk_page;
    assign lk_page = lk_addr[VA_W-1:OFF_W];

    // Lookup search
    logic [N_ENTRIES-1:0] lk_match;
    logic                 lk_any;
    logic [IDX_W-1:0]     lk_idx;

    tlb_cam #(.N_ENTRIES(N_ENTRIES), .PG_W(PG_W)) u_lk_cam (
        .valid(ent_v), .pages(ent_pg), .key(lk_page),
        .match(lk_match), .any(lk_any), .idx(lk_idx)
    );

    // Duplicate search for inserts
    logic [N_ENTRIES-1:0] ins_match;
    logic                 ins_dup;
    logic [IDX_W-1:0]     ins_dup_idx;

    tlb_cam #(.N_ENTRIES(N_ENTRIES), .PG_W(PG_W)) u_ins_cam (
        .valid(ent_v), .pages(ent_pg), .key(ins_page),
        .match(ins_match), .any(ins_dup), .idx(ins_dup_idx)
    );

    // Victim selection
    logic [IDX_W-1:0] rr_ptr;
    logic [IDX_W-1:0] vic_idx;
    victim_kind_e     vic_kind;

    tlb_victim #(.N_ENTRIES(N_ENTRIES)) u_victim (
        .valid(ent_v), .dirty(ent_d), .rr_ptr(rr_ptr),
        .vic_idx(vic_idx), .vic_kind(vic_kind)
    );

    // Controller
    logic lk_fire, ins_fire, fsm_wait;

    assign ins_fire = ins_valid && !flush;
    assign lk_fire  = lk_valid && lk_ready && !flush;

    tlb_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .lk_fire(lk_fire), .lk_hit(lk_any),
        .ins_fire(ins_fire), .flush(flush),
        .ready(lk_ready), .waiting(fsm_wait)
    );

    assign miss_req = fsm_wait;

    // Insert target and eviction
    logic [IDX_W-1:0] tgt_idx;
    logic             alloc, displaces;

    assign tgt_idx   = ins_dup ? ins_dup_idx : vic_idx;
    assign alloc     = ins_fire && !ins_dup;
    assign displaces = alloc && ent_v[vic_idx];

    // Table update
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ent_v <= '0;
            ent_d <= '0;
        end else begin
            for (int i = 0; i < N_ENTRIES; i++) begin
                if (ins_fire && tgt_idx == IDX_W'(i)) begin
                    ent_v[i]  <= 1'b1;
                    ent_pg[i] <= ins_page;
                    ent_fr[i] <= ins_frame;
                    ent_d[i]  <= ins_dup ? (ent_d[i] | (lk_fire && lk_write && lk_match[i]))
                                         : 1'b0;
                end else if (lk_fire && lk_write && lk_match[i]) begin
                    ent_d[i] <= 1'b1;
                end
            end
        end
    end

    // Rotating pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr <= '0;
        end else if (alloc && vic_kind == VIC_RR) begin
            if (rr_ptr == IDX_W'(N_ENTRIES - 1)) rr_ptr <= '0;
            else                                 rr_ptr <= rr_ptr + 1'b1;
        end
    end

    // Response and miss page
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_paddr <= '0;
            miss_page  <= '0;
        end else begin
            resp_valid <= lk_fire;
            if (lk_fire) begin
                resp_hit   <= lk_any;
                resp_paddr <= {ent_fr[lk_idx], lk_addr[OFF_W-1:0]};
                if (!lk_any) miss_page <= lk_page;
            end
        end
    end

    // Eviction report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evict_valid <= 1'b0;
            evict_page  <= '0;
            evict_dirty <= 1'b0;
        end else begin
            evict_valid <= displaces;
            if (displaces) begin
                evict_page  <= ent_pg[vic_idx];
                evict_dirty <= ent_d[vic_idx];
            end
        end
    end

endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
    parameter int VA_W  = 32,
    parameter int PA_W  = 24,
    parameter int OFF_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic [VA_W-1:0] lk_addr,
    input logic            ins_valid,
    input logic            flush,
    input logic            lk_ready,
    input logic            resp_valid,
    input logic            resp_hit,
    input logic [PA_W-1:0] resp_paddr,
    input logic            miss_req,
    input logic            evict_valid
);

    // R2
    resp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(lk_valid) && $past(lk_ready) && !$past(flush));

    // R2
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> resp_paddr[OFF_W-1:0] == $past(lk_addr[OFF_W-1:0]));

    // R3
    miss_enters_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_hit |-> miss_req);

    // R3
    wait_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_req |-> !lk_ready);

    // R3
    no_resp_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_req |=> !resp_valid);

    // R5
    fill_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_req && ins_valid |=> !miss_req && lk_ready);

    // R11
    flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !miss_req && lk_ready && !resp_valid);

    // R12
    flush_no_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !evict_valid);

    // R9
    evict_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> $past(ins_valid));

endmodule

bind addr_xlat_tlb tlb_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .ins_valid(ins_valid), .flush(flush), .lk_ready(lk_ready),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_paddr(resp_paddr),
    .miss_req(miss_req), .evict_valid(evict_valid)
);

// File: tb/tb_addr_xlat_tlb.sv
module tb_addr_xlat_tlb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0, lk_write = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_ready, resp_valid, resp_hit, miss_req;
    logic [23:0] resp_paddr;
    logic [19:0] miss_page;
    logic        ins_valid = 1'b0;
    logic [19:0] ins_page = '0;
    logic [11:0] ins_frame = '0;
    logic        flush = 1'b0;
    logic        evict_valid, evict_dirty;
    logic [19:0] evict_page;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    addr_xlat_tlb #(.N_ENTRIES(4)) dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write),
        .lk_addr(lk_addr), .lk_ready(lk_ready), .resp_valid(resp_valid),
        .resp_hit(resp_hit), .resp_paddr(resp_paddr), .miss_req(miss_req),
        .miss_page(miss_page), .ins_valid(ins_valid), .ins_page(ins_page),
        .ins_frame(ins_frame), .flush(flush), .evict_valid(evict_valid),
        .evict_page(evict_page), .evict_dirty(evict_dirty)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic lookup(logic [31:0] a, logic wr);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a; lk_write = wr;
        @(negedge clk);
        lk_valid = 1'b0; lk_write = 1'b0;
    endtask

    task automatic insert(logic [19:0] p, logic [11:0] f, logic fl);
        @(negedge clk);
        ins_valid = 1'b1; ins_page = p; ins_frame = f; flush = fl;
        @(negedge clk);
        ins_valid = 1'b0; flush = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic expect_evict(string req, logic v, logic [19:0] p, logic d);
        chk(req, 32'(evict_valid), 32'(v));
        if (v) begin
            chk(req, 32'(evict_page), 32'(p));
            chk(req, 32'(evict_dirty), 32'(d));
        end
    endtask

    // {addr, write, expected hit, expected physical address}
    localparam int NV = 6;
    localparam logic [57:0] VEC [NV] = '{
        {32'h12345ABC, 1'b0, 1'b1, 24'hA01ABC},
        {32'h00001000, 1'b1, 1'b1, 24'hF02000},
        {32'h00002FFF, 1'b0, 1'b1, 24'hF03FFF},
        {32'h000037FF, 1'b1, 1'b1, 24'hF047FF},
        {32'h12345001, 1'b1, 1'b1, 24'hA01001},
        {32'h00003800, 1'b0, 1'b1, 24'hF04800}
    };

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", 32'(lk_ready), 1);
        chk("R1", 32'(miss_req), 0);
        chk("R1", 32'(resp_valid), 0);
        chk("R1", 32'(evict_valid), 0);

        // R3 miss on empty table
        lookup(32'h12345ABC, 1'b0);
        chk("R3", 32'(resp_valid), 1);
        chk("R3", 32'(resp_hit), 0);
        chk("R3", 32'(miss_req), 1);
        chk("R3", 32'(miss_page), 32'h12345);
        chk("R3", 32'(lk_ready), 0);
        // R3 lookup during wait is ignored
        lookup(32'h00001000, 1'b0);
        chk("R3", 32'(resp_valid), 0);
        chk("R3", 32'(miss_req), 1);

        // R5 fill releases the wait; R6 into empty slots, R9 no eviction
        insert(20'h12345, 12'hA01, 1'b0);
        expect_evict("R9", 1'b0, '0, 1'b0);
        chk("R5", 32'(miss_req), 0);
        chk("R5", 32'(lk_ready), 1);
        insert(20'h00001, 12'hF02, 1'b0);
        expect_evict("R6", 1'b0, '0, 1'b0);
        insert(20'h00002, 12'hF03, 1'b0);
        insert(20'h00003, 12'hF04, 1'b0);
        expect_evict("R6", 1'b0, '0, 1'b0);

        // R2 / R4 table walk: hits, some writes
        for (int i = 0; i < NV; i++) begin
            lookup(VEC[i][57:26], VEC[i][25]);
            chk("R2", 32'(resp_valid), 1);
            chk("R2", 32'(resp_hit), 32'(VEC[i][24]));
            chk("R2", 32'(resp_paddr), 32'(VEC[i][23:0]));
        end

        // R10 duplicate insert overwrites frame, no eviction
        insert(20'h00002, 12'h0B0, 1'b0);
        expect_evict("R10", 1'b0, '0, 1'b0);
        lookup(32'h00002010, 1'b0);
        chk("R10", 32'(resp_paddr), 32'h0B0010);

        // R7 full table: lowest clean entry (page 2, clean)
        insert(20'h00040, 12'h111, 1'b0);
        expect_evict("R7", 1'b1, 20'h00002, 1'b0);
        lookup(32'h00040000, 1'b1);
        chk("R2", 32'(resp_paddr), 32'h111000);

        // R8 all dirty: rotating pointer starts at entry 0
        insert(20'h00050, 12'h222, 1'b0);
        expect_evict("R8", 1'b1, 20'h12345, 1'b1);
        lookup(32'h00050000, 1'b1);
        // R8 pointer advanced to entry 1
        insert(20'h00060, 12'h333, 1'b0);
        expect_evict("R8", 1'b1, 20'h00001, 1'b1);

        // R4 read hit leaves the entry unmodified
        lookup(32'h00060ABC, 1'b0);
        chk("R4", 32'(resp_paddr), 32'h333ABC);
        insert(20'h00070, 12'h444, 1'b0);
        expect_evict("R4", 1'b1, 20'h00060, 1'b0);

        // R11 flush aborts an outstanding miss and empties the table
        lookup(32'h00001000, 1'b0);
        chk("R3", 32'(resp_hit), 0);
        do_flush();
        chk("R11", 32'(miss_req), 0);
        chk("R11", 32'(lk_ready), 1);
        lookup(32'h00070000, 1'b0);
        chk("R11", 32'(resp_hit), 0);
        chk("R11", 32'(miss_req), 1);

        // R12 insert colliding with flush is discarded
        insert(20'h00070, 12'h555, 1'b1);
        chk("R12", 32'(miss_req), 0);
        chk("R12", 32'(evict_valid), 0);
        lookup(32'h00070000, 1'b0);
        chk("R12", 32'(resp_hit), 0);
        insert(20'h00070, 12'h555, 1'b0);
        lookup(32'h00070123, 1'b0);
        chk("R5", 32'(resp_hit), 1);
        chk("R5", 32'(resp_paddr), 32'h555123);

        // R6 fill order after flush: slot 0 is lowest clean when full
        insert(20'h00080, 12'h666, 1'b0);
        insert(20'h00090, 12'h777, 1'b0);
        insert(20'h000A0, 12'h888, 1'b0);
        expect_evict("R6", 1'b0, '0, 1'b0);
        insert(20'h000B0, 12'h999, 1'b0);
        expect_evict("R6", 1'b1, 20'h00070, 1'b0);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

endmodule